// File: doc/BRIEF.md
# Thermal and Overvoltage Protection Supervisor

This block guards a bank of four high-side switch channels. Each clock cycle it reads a digitized die temperature in degrees Celsius and a digitized supply voltage in volts. From these it decides whether the four commanded ON bits may reach the switches. A rising temperature first raises an early-warning flag while the channels keep running. If the temperature keeps rising to the trip point, all four channels are cut together, no matter which channel causes the heating. They come back only after the die has cooled to a lower release point.

A supply above its limit also cuts every channel. That cutoff lasts only while the excess lasts. Both inputs are signed 10-bit integers, and every threshold is a module parameter. The status flags are registered. The effective enables follow the commands combinationally, gated by those registered states.

Top module: `prot_supervisor`

## Requirements
- R1: When neither the thermal-off state nor the overvoltage flag is set, `sw_en` equals `cmd_on`, bit for bit, in the same cycle.
- R2: A temperature of 170 or more sampled at a clock edge sets `therm_off` after that edge, and `sw_en` is then 4'b0000 whatever `cmd_on` holds.
- R3: A temperature of 160 or less sampled at a clock edge clears `therm_off` after that edge.
- R4: A temperature from 161 to 169 leaves `therm_off` at its previous value, so repeated heating and cooling makes the enables cycle between the two thresholds.
- R5: `warn_hot` is set after an edge where the temperature exceeds 145, and is clear otherwise. It has no effect on `sw_en`.
- R6: `over_volt` is set after an edge where the supply exceeds 35, and forces `sw_en` to 4'b0000. It clears after the first edge where the supply is 35 or less, with no latching.
- R7: While `rst_n` is low, all three flags are 0 and `sw_en` equals `cmd_on`, even with a hot die or a high supply.
- R8: Both inputs are treated as two's-complement values, so negative temperatures and supplies never raise a flag.
- R9: With thermal shutdown and overvoltage both active, `sw_en` stays 4'b0000 until both have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_c | input | 10 | Signed die temperature, degrees Celsius |
| vsup_v | input | 10 | Signed supply voltage, volts |
| cmd_on | input | 4 | Commanded ON bit per channel |
| sw_en | output | 4 | Effective switch enable per channel |
| warn_hot | output | 1 | Early temperature warning |
| therm_off | output | 1 | Thermal shutdown active |
| over_volt | output | 1 | Supply above limit |

## Verification
Thermal shutdown and overvoltage can both apply in the same cycle. Two events can also coincide: one cutoff ends while the other is still active. The bench provokes these cases with directed sequences, and also with random supplies that straddle 35 while the temperature wanders across the hysteresis band. A reference model in the bench holds its own latched thermal state. In every cycle it predicts the enables from the union of both cutoffs and compares them with the enables at the ports.

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
  parameter int W         = 10,
  parameter int CH        = 4,
  parameter int T_TRIP    = 170,
  parameter int T_RELEASE = 160,
  parameter int T_WARN    = 145,
  parameter int V_MAX     = 35
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] temp_c,
  input  logic signed [W-1:0] vsup_v,
  input  logic [CH-1:0]       cmd_on,
  output logic [CH-1:0]       sw_en,
  output logic                warn_hot,
  output logic                therm_off,
  output logic                over_volt
);

  localparam logic signed [W-1:0] TRIP = W'(T_TRIP);
  localparam logic signed [W-1:0] REL  = W'(T_RELEASE);
  localparam logic signed [W-1:0] WARN = W'(T_WARN);
  localparam logic signed [W-1:0] VMX  = W'(V_MAX);

  wire at_trip  = temp_c >= TRIP;
  wire at_rel   = temp_c <= REL;
  wire hot_warn = temp_c >  WARN;
  wire ov_now   = vsup_v >  VMX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm_off <= 1'b0;
      warn_hot  <= 1'b0;
      over_volt <= 1'b0;
    end else begin
      if (at_trip)     therm_off <= 1'b1;
      else if (at_rel) therm_off <= 1'b0;
      warn_hot  <= hot_warn;
      over_volt <= ov_now;
    end
  end

  assign sw_en = cmd_on & {CH{~(therm_off | over_volt)}};

  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    at_trip |=> therm_off);  // R2
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    at_rel |=> !therm_off);  // R3
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_trip && !at_rel) |=> $stable(therm_off));  // R4
  AST_WARN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> warn_hot == $past(hot_warn));  // R5
  AST_OV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> over_volt == $past(ov_now));  // R6
  AST_CUT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_off || over_volt) |-> sw_en == '0);  // R9

endmodule

// File: tb/prot_supervisor_bench.sv
module prot_supervisor_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [9:0] temp_c = '0;
  logic signed [9:0] vsup_v = '0;
  logic [3:0] cmd_on = '0;
  logic [3:0] sw_en;
  logic warn_hot, therm_off, over_volt;

  int checks = 0;
  int errors = 0;
  logic hot_m = 1'b0;
  logic warn_m = 1'b0;
  logic ov_m = 1'b0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  prot_supervisor u_prot_supervisor (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .vsup_v(vsup_v),
    .cmd_on(cmd_on), .sw_en(sw_en), .warn_hot(warn_hot),
    .therm_off(therm_off), .over_volt(over_volt)
  );

  function automatic logic next_hot(input logic h, input int t);
    if (t >= 170) return 1'b1;
    if (t <= 160) return 1'b0;
    return h;
  endfunction

  function automatic logic [3:0] exp_en(input logic [3:0] c, input logic h, input logic o);
    return (h || o) ? 4'b0000 : c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int t, input int v, input logic [3:0] c);
    string tag;
    temp_c = 10'(t); vsup_v = 10'(v); cmd_on = c;
    @(posedge clk);
    hot_m = next_hot(hot_m, t); warn_m = (t > 145); ov_m = (v > 35);
    @(negedge clk);
    if (hot_m && ov_m) tag = "R9";
    else if (ov_m) tag = "R6";
    else if (hot_m) tag = "R2";
    else tag = "R1";
    chk(tag, sw_en, exp_en(c, hot_m, ov_m));
    if (t >= 170) tag = "R2"; else if (t <= 160) tag = "R3"; else tag = "R4";
    chk(tag, therm_off, hot_m);
    chk("R5", warn_hot, warn_m);
    chk("R6", over_volt, ov_m);
  endtask

  initial begin
    #(CLK_NS*100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    temp_c = 10'sd250; vsup_v = 10'sd60; cmd_on = 4'b1010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset holds flags low, enables pass through
    chk("R7", sw_en, 4'b1010);
    chk("R7", therm_off, 0);
    chk("R7", warn_hot, 0);
    chk("R7", over_volt, 0);
    rst_n = 1'b1;

    step(25, 12, 4'b1111);   // R1
    step(146, 12, 4'b0101);  // R5 warn, enables untouched
    step(145, 12, 4'b0101);
    step(169, 12, 4'b1100);  // R4 band, no trip yet
    step(170, 12, 4'b1111);  // R2 trip
    step(165, 12, 4'b1111);  // R4 held off
    step(161, 12, 4'b0011);
    step(160, 12, 4'b0011);  // R3 release
    step(165, 12, 4'b1001);  // R4 stays on
    step(30, 35, 4'b1111);   // R6 boundary not over
    step(30, 36, 4'b1111);   // R6 over
    step(30, 35, 4'b1111);   // R6 not latched
    step(-300, -20, 4'b1111); // R8 negatives
    step(-512, -512, 4'b0110); // R8
    // R9 overlap: both on, release one at a time
    step(180, 40, 4'b1111);
    step(150, 40, 4'b1111);  // thermal clears, OV remains
    step(150, 20, 4'b1111);
    step(175, 50, 4'b1111);
    step(175, 10, 4'b1111);  // OV clears, thermal remains
    step(120, 10, 4'b1111);
    // R4 cycling between thresholds
    for (int k = 0; k < 3; k++) begin
      for (int t = 158; t <= 172; t += 2) step(t, 24, 4'b1111);
      for (int t = 172; t >= 158; t -= 2) step(t, 24, 4'b1111);
    end
    // random
    for (int i = 0; i < 500; i++) begin
      int t, v;
      t = 130 + int'($urandom_range(0, 55));
      if ($urandom_range(0, 9) == 0) t = int'($urandom_range(0, 1023)) - 512;
      v = 30 + int'($urandom_range(0, 10));
      if ($urandom_range(0, 9) == 0) v = int'($urandom_range(0, 1023)) - 512;
      step(t, v, 4'($urandom_range(0, 15)));
    end
    // R7: reset mid-shutdown clears state
    step(200, 50, 4'b1111);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    hot_m = 0; warn_m = 0; ov_m = 0;
    chk("R7", therm_off, 0);
    chk("R7", sw_en, 4'b1111);
    rst_n = 1'b1;
    step(100, 10, 4'b0110);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule